// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence for a four-beat memory burst. A burst is opened when either of two active-low start strobes is sampled low. At that edge the block captures the external start address, and it also captures the order select. On each later clock where the active-low step input is sampled low, the two low address bits move to the next beat. While step is high, the address holds.

Two beat orders are available. The linear order adds the beat count to the start address, modulo four. The interleaved order XORs the start address with the beat count. The upper address bits are only loaded, never incremented, so a burst cannot carry across its aligned four-word block. After four steps the low bits wrap back to the start value.

The block has no data stream, only control pins and an address. There is no valid/ready interface, and the address is valid on every cycle once reset has been released.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst` is sampled high, `cur_addr` reads 0 after that edge and the beat count returns to 0.
- R2: When either `strb_cpu_n` or `strb_ctl_n` is sampled low, `cur_addr` equals the sampled `ext_addr` after that edge.
- R3: A start strobe takes priority over `step_n`. If both are asserted on the same edge, the start address is loaded and no step is taken.
- R4: When both strobes are high and `step_n` is high, `cur_addr` is unchanged across the edge.
- R5: With the order captured as linear (`ileave_sel`=0), beat k has low bits (start + k) mod 4. From start 01 the order is 01,10,11,00.
- R6: With the order captured as interleaved (`ileave_sel`=1), beat k has low bits start XOR k. From start 01 the order is 01,00,11,10, and from start 10 it is 10,11,00,01.
- R7: `ileave_sel` is sampled only at a burst start. A change to it during a burst has no effect on the sequence.
- R8: After four steps the low bits return to the start value. Bits above [1:0] change only when a start strobe is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ileave_sel | input | 1 | Order select: 1 = interleaved, 0 = linear; sampled at burst start |
| strb_cpu_n | input | 1 | Processor-side burst start strobe, active low |
| strb_ctl_n | input | 1 | Controller-side burst start strobe, active low |
| step_n | input | 1 | Advance to the next beat, active low |
| ext_addr | input | ADDR_W (16) | External start address |
| cur_addr | output | ADDR_W (16) | Current burst address |

## Verification
The assertions assume that `rst` is driven to a known level from the first clock edge. They also assume that the strobe and step inputs are never X on an edge where reset is low, because the load and hold properties use those inputs as their antecedents. The bench meets both conditions. It holds reset across the first edges, and it drives every control input to a defined level a nanosecond after each rising edge, well clear of the next edge. The bench also keeps `ext_addr` and `ileave_sel` defined whenever a strobe may sample them.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    logic load;
    logic step;
  } burst_cmd_t;
endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_pkg::*;
(
  input  logic       strb_cpu_n,
  input  logic       strb_ctl_n,
  input  logic       step_n,
  output burst_cmd_t cmd
);
  always_comb begin
    cmd.load = ~strb_cpu_n | ~strb_ctl_n;
    cmd.step = ~cmd.load & ~step_n;  // a start strobe wins over a step
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_cmd_t        cmd,
  output logic [BEAT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || cmd.load) cnt <= '0;
    else if (cmd.step)   cnt <= cnt + 1'b1;  // wraps naturally modulo 2**BEAT_W
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              ileave_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base_addr,
  output order_e            order
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      order     <= ORD_LINEAR;
    end else if (load) begin
      base_addr <= ext_addr;
      order     <= ileave_sel ? ORD_INTERLEAVE : ORD_LINEAR;
    end
  end
endmodule

// File: rtl/order_map.sv
module order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] cnt,
  input  order_e            order,
  output logic [BEAT_W-1:0] beat
);
  logic [BEAT_W-1:0] lin_beat;
  logic [BEAT_W-1:0] ilv_beat;

  assign lin_beat = start + cnt;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_beat[b] = start[b] ^ cnt[b];
  end

  assign beat = (order == ORD_INTERLEAVE) ? ilv_beat : lin_beat;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ileave_sel,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              step_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  burst_cmd_t        cmd;
  logic [BEAT_W-1:0] cnt;
  logic [ADDR_W-1:0] base_addr;
  order_e            order;
  logic [BEAT_W-1:0] beat;

  burst_ctl ctl_i (
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .step_n     (step_n),
    .cmd        (cmd)
  );

  beat_counter #(.BEAT_W(BEAT_W)) cnt_i (
    .clk (clk),
    .rst (rst),
    .cmd (cmd),
    .cnt (cnt)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) base_i (
    .clk        (clk),
    .rst        (rst),
    .load       (cmd.load),
    .ileave_sel (ileave_sel),
    .ext_addr   (ext_addr),
    .base_addr  (base_addr),
    .order      (order)
  );

  order_map #(.BEAT_W(BEAT_W)) map_i (
    .start (base_addr[BEAT_W-1:0]),
    .cnt   (cnt),
    .order (order),
    .beat  (beat)
  );

  // upper bits pass straight from the loaded base: no carry out of the beat field
  assign cur_addr = {base_addr[ADDR_W-1 -: HI_W], beat};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              step_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr
);
  logic start_any;
  assign start_any = ~strb_cpu_n | ~strb_ctl_n;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> cur_addr == '0);

  // R2, R3
  a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
    start_any |=> cur_addr == $past(ext_addr));

  // R4
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!start_any && step_n) |=> $stable(cur_addr));

  // R5, R6: every step moves the low bits
  a_r6_step_moves: assert property (@(posedge clk) disable iff (rst)
    (!start_any && !step_n) |=> cur_addr[BEAT_W-1:0] != $past(cur_addr[BEAT_W-1:0]));

  // R8
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    !start_any |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .step_n     (step_n),
  .ext_addr   (ext_addr),
  .cur_addr   (cur_addr)
);

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ileave_sel = 1'b0;
  logic          strb_cpu_n = 1'b1;
  logic          strb_ctl_n = 1'b1;
  logic          step_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .ileave_sel (ileave_sel),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .step_n     (step_n),
    .ext_addr   (ext_addr),
    .cur_addr   (cur_addr)
  );

  function automatic logic [1:0] exp_low(logic [1:0] s, int k, bit ilv);
    logic [1:0] kk;
    kk = k[1:0];
    return ilv ? (s ^ kk) : (s + kk);
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    checks++;
    if (cur_addr !== exp) begin
      failures++;
      $display("FAIL %s: cur_addr=%h expected=%h", req, cur_addr, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start_burst(logic [AW-1:0] a, bit ilv, bit use_cpu);
    ext_addr   = a;
    ileave_sel = ilv;
    strb_cpu_n = !use_cpu;
    strb_ctl_n = use_cpu;
    step_n     = 1'b1;
    tick();
    strb_cpu_n = 1'b1;
    strb_ctl_n = 1'b1;
    ext_addr   = ~a;  // later changes must not matter
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick();
    tick();
    check("R1 reset", '0);
    rst = 1'b0;
  endtask

  task automatic t_strobes();
    start_burst(16'h1234, 1'b0, 1'b1);
    check("R2 cpu strobe load", 16'h1234);
    start_burst(16'hA5C7, 1'b1, 1'b0);
    check("R2 ctl strobe load", 16'hA5C7);
  endtask

  task automatic t_order(bit ilv, string req);
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] base;
      base = 16'h3C40 | AW'(s);
      start_burst(base, ilv, s[0]);
      for (int k = 1; k < 4; k++) begin
        step_n = 1'b0;
        tick();
        check(req, {base[AW-1:2], exp_low(base[1:0], k, ilv)});
      end
      step_n = 1'b1;
    end
  endtask

  task automatic t_hold();
    start_burst(16'h0F02, 1'b1, 1'b1);
    step_n = 1'b0;
    tick();
    step_n = 1'b1;
    tick();
    tick();
    check("R4 hold", 16'h0F03);
    step_n = 1'b0;
    tick();
    check("R4 resume after hold", 16'h0F00);
    step_n = 1'b1;
  endtask

  task automatic t_priority();
    start_burst(16'h5551, 1'b0, 1'b1);
    step_n = 1'b0;
    tick();
    ext_addr   = 16'h7772;
    strb_ctl_n = 1'b0;
    tick();  // step_n still low
    strb_ctl_n = 1'b1;
    step_n     = 1'b1;
    check("R3 strobe beats step", 16'h7772);
  endtask

  task automatic t_mode_mid();
    start_burst(16'h2001, 1'b1, 1'b0);
    ileave_sel = 1'b0;
    step_n = 1'b0;
    tick();
    check("R7 mode ignored mid-burst", 16'h2000);
    tick();
    check("R7 mode ignored mid-burst", 16'h2003);
    step_n = 1'b1;
  endtask

  task automatic t_wrap();
    start_burst(16'hFFFE, 1'b0, 1'b1);
    step_n = 1'b0;
    tick();
    check("R8 no carry", 16'hFFFF);
    tick();
    check("R8 no carry", 16'hFFFC);
    tick();
    tick();
    check("R8 wrap to start", 16'hFFFE);
    tick();
    check("R8 wrap continues", 16'hFFFF);
    step_n = 1'b1;
    start_burst(16'h8003, 1'b1, 1'b0);
    step_n = 1'b0;
    for (int k = 0; k < 4; k++) tick();
    check("R8 interleaved wrap", 16'h8003);
    step_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_strobes();
    t_order(1'b0, "R5 linear order");
    t_order(1'b1, "R6 interleaved order");
    t_hold();
    t_priority();
    t_mode_mid();
    t_wrap();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule